// File: doc/BRIEF.md
# ATA PIO Single-Sector Transfer Sequencer

This block moves one 512-byte sector between a host word buffer and an ATA drive, using programmed I/O through the drive's task-file registers. A request carries the direction, the drive choice (master or slave), the sector number, both cylinder bytes and the head nibble. The sequencer first wins a per-channel lock from an external arbiter. It then selects the drive and lets it settle, programs the address registers in a fixed order and issues the read or write command. After that it walks the status-gated data phase and waits for the drive interrupt. It ends the request with a one-cycle done or error pulse.

The task-file port is a single-cycle access bus: one register code and one strobe per cycle. Read data is taken at the clock edge that closes the access. During a write data phase, one word per cycle passes combinationally from the host buffer to the data register. During a read data phase, one word per cycle passes from the data register into the buffer. Every wait on the drive is bounded by a cycle timeout, and an expired timeout ends the request in error.

Top module: `ata_pio_sector_seq`

## Requirements
- R1: The first access after the lock is granted writes the drive register (code 6) with 0xA0 OR (slave<<4). The next access follows exactly SEL_WAIT idle cycles later.
- R2: After the settle time, registers are written in this order with no gaps: control (code 8) = 0x08, feature (code 1) = 0x01, feature = 0x00, count (code 2) = 0x01, sector (code 3), cylinder low (code 4), cylinder high (code 5), drive (code 6) = 0xA0 OR (slave<<4) OR head.
- R3: The command (code 7) is then written as 0x20 for a read or 0x30 for a write. Status (a read of code 7) is polled until BSY (bit 7) is clear.
- R4: If ERR (bit 0) is set in the first status read with BSY clear, the request ends with err_o and no data phase takes place.
- R5: For a write, status is polled until BSY is clear and DRQ (bit 3) is set. Then WORDS words from buffer indexes 0 to WORDS-1 are written, in order, to the data register (code 0). Status is then polled until BSY and DRQ are both clear. ERR set on any of these polls ends the request with err_o.
- R6: After the write data phase, or straight after the read command poll, the sequencer waits for the interrupt and then makes one alternate-status read (code 8). A read request makes one more alternate-status read after its data phase.
- R7: For a read, after the interrupt, status is polled until BSY is clear and DRQ is set. Then WORDS data-register reads are stored, in order, at buffer indexes 0 to WORDS-1.
- R8: A rising edge of irq_i is held pending. Pending is cleared in the cycle the command is written. An edge before the command is therefore ignored, and an edge after the command but before the interrupt wait is not lost.
- R9: A final status read gives err_o if ERR is set and done_o otherwise. done_o and err_o are single-cycle pulses, never both high, and lock_req_o is low in that cycle.
- R10: lock_req_o rises when a request is accepted. No task-file access occurs before lock_gnt_i, and every access occurs with lock_req_o high.
- R11: Each status poll, and the interrupt wait, that does not reach its exit condition within TIMEOUT cycles ends the request with err_o.
- R12: After reset, busy_o, lock_req_o, done_o, err_o and all strobes are low. A request is accepted only while busy_o is low; req_valid_i has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_write_i | input | 1 | 1 = write sector, 0 = read sector |
| req_slave_i | input | 1 | 1 = slave drive, 0 = master |
| req_sect_i | input | 8 | Sector number byte |
| req_cyl_lo_i | input | 8 | Cylinder low byte |
| req_cyl_hi_i | input | 8 | Cylinder high byte |
| req_head_i | input | 4 | Head nibble |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure pulse |
| lock_req_o | output | 1 | Channel lock request |
| lock_gnt_i | input | 1 | Channel lock grant |
| tf_wr_o | output | 1 | Task-file write strobe |
| tf_rd_o | output | 1 | Task-file read strobe |
| tf_reg_o | output | 4 | Register code (0 data .. 7 status/command, 8 control/alt status) |
| tf_wdata_o | output | 16 | Task-file write data |
| tf_rdata_i | input | 16 | Task-file read data, taken at the closing edge |
| irq_i | input | 1 | Drive interrupt line |
| buf_idx_o | output | 8 | Host buffer word index |
| buf_rd_o | output | 1 | Buffer word fetch (write data phase) |
| buf_rdata_i | input | 16 | Buffer word for the current index |
| buf_wr_o | output | 1 | Buffer word store (read data phase) |
| buf_wdata_o | output | 16 | Word to store |

## Verification
The assertions assume an arbiter that keeps lock_gnt_i high for as long as lock_req_o stays high. They also assume a drive that answers each access in the same cycle. The bench's grant model raises the grant a set number of cycles after the request and drops it only when the request falls. Its drive model returns each status and data word from an explicit phase variable. The drive model pulses irq_i only in the windows a given test asks for, with the pre-command pulse as the one deliberate stray edge.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  typedef enum logic [4:0] {
    S_IDLE, S_LOCK, S_SEL, S_SETTLE, S_PROG, S_CMD, S_POLL_BSY,
    S_W_DRQ, S_W_DATA, S_W_END, S_IRQ_WAIT, S_ALT1, S_R_DRQ,
    S_R_DATA, S_ALT2, S_FINAL, S_DONE, S_ERR
  } seq_state_e;

  localparam logic [3:0] REG_DATA   = 4'd0;
  localparam logic [3:0] REG_FEAT   = 4'd1;
  localparam logic [3:0] REG_COUNT  = 4'd2;
  localparam logic [3:0] REG_SECT   = 4'd3;
  localparam logic [3:0] REG_CYL_LO = 4'd4;
  localparam logic [3:0] REG_CYL_HI = 4'd5;
  localparam logic [3:0] REG_DRIVE  = 4'd6;
  localparam logic [3:0] REG_CMD    = 4'd7;
  localparam logic [3:0] REG_CTRL   = 4'd8;

  localparam int ST_ERR = 0;
  localparam int ST_DRQ = 3;
  localparam int ST_BSY = 7;

  localparam logic [7:0] DRV_BASE = 8'hA0;
  localparam logic [7:0] CTRL_IEN = 8'h08;
  localparam logic [7:0] CMD_RD   = 8'h20;
  localparam logic [7:0] CMD_WR   = 8'h30;

  localparam int PROG_STEPS = 8;

  typedef struct packed {
    logic       write;
    logic       slave;
    logic [7:0] sect;
    logic [7:0] cyl_lo;
    logic [7:0] cyl_hi;
    logic [3:0] head;
  } seq_req_t;
endpackage

// File: rtl/ata_irq_latch.sv
module ata_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic clr_i,
  output logic pend_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      irq_q <= irq_i;
      if (clr_i)               pend_o <= 1'b0;
      else if (irq_i && !irq_q) pend_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ata_wait_timer.sv
module ata_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (restart_i)     cnt_o <= '0;
    else if (cnt_o != '1)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ata_word_counter.sv
module ata_word_counter #(
  parameter int WORDS = 256,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [AW-1:0] idx_o,
  output logic          last_o
);
  assign last_o = (idx_o == AW'(WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idx_o <= '0;
    else if (!en_i || last_o)    idx_o <= '0;
    else                         idx_o <= idx_o + 1'b1;
  end
endmodule

// File: rtl/ata_prog_step.sv
module ata_prog_step
  import ata_seq_pkg::*;
(
  input  logic [2:0] step_i,
  input  seq_req_t   req_i,
  output logic [3:0] reg_o,
  output logic [7:0] data_o
);
  logic [7:0] drv_sel;
  assign drv_sel = DRV_BASE | {3'b000, req_i.slave, 4'b0000};

  always_comb begin
    unique case (step_i)
      3'd0: begin reg_o = REG_CTRL;   data_o = CTRL_IEN; end
      3'd1: begin reg_o = REG_FEAT;   data_o = 8'h01; end
      3'd2: begin reg_o = REG_FEAT;   data_o = 8'h00; end
      3'd3: begin reg_o = REG_COUNT;  data_o = 8'h01; end
      3'd4: begin reg_o = REG_SECT;   data_o = req_i.sect; end
      3'd5: begin reg_o = REG_CYL_LO; data_o = req_i.cyl_lo; end
      3'd6: begin reg_o = REG_CYL_HI; data_o = req_i.cyl_hi; end
      default: begin reg_o = REG_DRIVE; data_o = drv_sel | {4'b0000, req_i.head}; end
    endcase
  end
endmodule

// File: rtl/ata_pio_sector_seq.sv
module ata_pio_sector_seq
  import ata_seq_pkg::*;
#(
  parameter int WORDS    = 256,
  parameter int SEL_WAIT = 20000,
  parameter int TIMEOUT  = 1000000,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int TMAX = (SEL_WAIT > TIMEOUT) ? SEL_WAIT : TIMEOUT,
  localparam int TW   = $clog2(TMAX + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_slave_i,
  input  logic [7:0]    req_sect_i,
  input  logic [7:0]    req_cyl_lo_i,
  input  logic [7:0]    req_cyl_hi_i,
  input  logic [3:0]    req_head_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          lock_req_o,
  input  logic          lock_gnt_i,
  output logic          tf_wr_o,
  output logic          tf_rd_o,
  output logic [3:0]    tf_reg_o,
  output logic [15:0]   tf_wdata_o,
  input  logic [15:0]   tf_rdata_i,
  input  logic          irq_i,
  output logic [AW-1:0] buf_idx_o,
  output logic          buf_rd_o,
  input  logic [15:0]   buf_rdata_i,
  output logic          buf_wr_o,
  output logic [15:0]   buf_wdata_o
);
  seq_state_e state_q, state_d;
  seq_req_t   req_q;
  logic [2:0] step_q;
  logic [TW-1:0] tmr;
  logic irq_pend, irq_clr;
  logic word_en, word_last;
  logic [3:0] prog_reg;
  logic [7:0] prog_data;
  logic st_bsy, st_drq, st_err, timed_out, settled;

  assign st_bsy    = tf_rdata_i[ST_BSY];
  assign st_drq    = tf_rdata_i[ST_DRQ];
  assign st_err    = tf_rdata_i[ST_ERR];
  assign timed_out = (tmr == TW'(TIMEOUT - 1));
  assign settled   = (tmr == TW'(SEL_WAIT - 1));

  ata_irq_latch u_irq (
    .clk_i, .rst_ni, .irq_i, .clr_i(irq_clr), .pend_o(irq_pend)
  );

  ata_wait_timer #(.W(TW)) u_tmr (
    .clk_i, .rst_ni, .restart_i(state_d != state_q), .cnt_o(tmr)
  );

  ata_word_counter #(.WORDS(WORDS)) u_words (
    .clk_i, .rst_ni, .en_i(word_en), .idx_o(buf_idx_o), .last_o(word_last)
  );

  ata_prog_step u_prog (
    .step_i(step_q), .req_i(req_q), .reg_o(prog_reg), .data_o(prog_data)
  );

  assign word_en    = (state_q == S_W_DATA) || (state_q == S_R_DATA);
  assign busy_o     = (state_q != S_IDLE);
  assign lock_req_o = !(state_q inside {S_IDLE, S_DONE, S_ERR});
  assign done_o     = (state_q == S_DONE);
  assign err_o      = (state_q == S_ERR);

  always_comb begin
    state_d     = state_q;
    tf_wr_o     = 1'b0;
    tf_rd_o     = 1'b0;
    tf_reg_o    = REG_CMD;
    tf_wdata_o  = '0;
    buf_rd_o    = 1'b0;
    buf_wr_o    = 1'b0;
    buf_wdata_o = tf_rdata_i;
    irq_clr     = 1'b0;
    unique case (state_q)
      S_IDLE:   if (req_valid_i) state_d = S_LOCK;
      S_LOCK:   if (lock_gnt_i) state_d = S_SEL;
      S_SEL: begin
        tf_wr_o    = 1'b1;
        tf_reg_o   = REG_DRIVE;
        tf_wdata_o = {8'h00, DRV_BASE | {3'b000, req_q.slave, 4'b0000}};
        state_d    = S_SETTLE;
      end
      S_SETTLE: if (settled) state_d = S_PROG;
      S_PROG: begin
        tf_wr_o    = 1'b1;
        tf_reg_o   = prog_reg;
        tf_wdata_o = {8'h00, prog_data};
        if (step_q == 3'(PROG_STEPS - 1)) state_d = S_CMD;
      end
      S_CMD: begin
        tf_wr_o    = 1'b1;
        tf_reg_o   = REG_CMD;
        tf_wdata_o = {8'h00, req_q.write ? CMD_WR : CMD_RD};
        irq_clr    = 1'b1;
        state_d    = S_POLL_BSY;
      end
      S_POLL_BSY: begin
        tf_rd_o = 1'b1;
        if (!st_bsy) begin
          if (st_err)           state_d = S_ERR;
          else if (req_q.write) state_d = S_W_DRQ;
          else                  state_d = S_IRQ_WAIT;
        end else if (timed_out) state_d = S_ERR;
      end
      S_W_DRQ: begin
        tf_rd_o = 1'b1;
        if (st_err)                  state_d = S_ERR;
        else if (!st_bsy && st_drq)  state_d = S_W_DATA;
        else if (timed_out)          state_d = S_ERR;
      end
      S_W_DATA: begin
        tf_wr_o    = 1'b1;
        tf_reg_o   = REG_DATA;
        tf_wdata_o = buf_rdata_i;
        buf_rd_o   = 1'b1;
        if (word_last) state_d = S_W_END;
      end
      S_W_END: begin
        tf_rd_o = 1'b1;
        if (st_err)                  state_d = S_ERR;
        else if (!st_bsy && !st_drq) state_d = S_IRQ_WAIT;
        else if (timed_out)          state_d = S_ERR;
      end
      S_IRQ_WAIT: begin
        if (irq_pend)       state_d = S_ALT1;
        else if (timed_out) state_d = S_ERR;
      end
      S_ALT1: begin
        tf_rd_o  = 1'b1;
        tf_reg_o = REG_CTRL;
        state_d  = req_q.write ? S_FINAL : S_R_DRQ;
      end
      S_R_DRQ: begin
        tf_rd_o = 1'b1;
        if (st_err)                 state_d = S_ERR;
        else if (!st_bsy && st_drq) state_d = S_R_DATA;
        else if (timed_out)         state_d = S_ERR;
      end
      S_R_DATA: begin
        tf_rd_o  = 1'b1;
        tf_reg_o = REG_DATA;
        buf_wr_o = 1'b1;
        if (word_last) state_d = S_ALT2;
      end
      S_ALT2: begin
        tf_rd_o  = 1'b1;
        tf_reg_o = REG_CTRL;
        state_d  = S_FINAL;
      end
      S_FINAL: begin
        tf_rd_o = 1'b1;
        state_d = st_err ? S_ERR : S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      S_ERR:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      req_q   <= '0;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && req_valid_i)
        req_q <= '{write: req_write_i, slave: req_slave_i, sect: req_sect_i,
                   cyl_lo: req_cyl_lo_i, cyl_hi: req_cyl_hi_i, head: req_head_i};
      step_q <= (state_q == S_PROG) ? step_q + 3'd1 : 3'd0;
    end
  end
endmodule

// File: rtl/ata_pio_sector_seq_chk.sv
module ata_pio_sector_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          lock_req_o,
  input logic          lock_gnt_i,
  input logic          tf_wr_o,
  input logic          tf_rd_o,
  input logic [3:0]    tf_reg_o,
  input logic [15:0]   tf_wdata_o,
  input logic          buf_rd_o,
  input logic [15:0]   buf_rdata_i,
  input logic          buf_wr_o
);
  AST_ACCESS_UNDER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tf_wr_o || tf_rd_o) |-> (lock_req_o && lock_gnt_i)); // R10
  AST_NO_ACCESS_AT_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_req_o) |-> !(tf_wr_o || tf_rd_o)); // R10
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tf_wr_o && tf_rd_o)); // R2
  AST_CMD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tf_wr_o && tf_reg_o == 4'd7) |-> (tf_wdata_o == 16'h0020 || tf_wdata_o == 16'h0030)); // R3
  AST_WR_WORD_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_o |-> (tf_wr_o && tf_reg_o == 4'd0 && tf_wdata_o == buf_rdata_i)); // R5
  AST_RD_WORD_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> (tf_rd_o && tf_reg_o == 4'd0)); // R7
  AST_END_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> (!lock_req_o && !(done_o && err_o))); // R9
  AST_END_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> !(done_o || err_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(lock_req_o || done_o || err_o || tf_wr_o || tf_rd_o)); // R12
endmodule

bind ata_pio_sector_seq ata_pio_sector_seq_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .busy_o, .done_o, .err_o, .lock_req_o, .lock_gnt_i,
  .tf_wr_o, .tf_rd_o, .tf_reg_o, .tf_wdata_o, .buf_rd_o, .buf_rdata_i, .buf_wr_o
);

// File: tb/tb_ata_pio_sector_seq.sv
`timescale 1ns/1ps
module tb_ata_pio_sector_seq;
  localparam int WORDS = 256, SEL_WAIT = 20, TIMEOUT = 40;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_write_i = 0, req_slave_i = 0;
  logic [7:0] req_sect_i = 0, req_cyl_lo_i = 0, req_cyl_hi_i = 0;
  logic [3:0] req_head_i = 0;
  logic busy_o, done_o, err_o, lock_req_o, lock_gnt_i = 0;
  logic tf_wr_o, tf_rd_o;
  logic [3:0] tf_reg_o;
  logic [15:0] tf_wdata_o, tf_rdata_i = 16'h0050;
  logic irq_i = 0;
  logic [7:0] buf_idx_o;
  logic buf_rd_o, buf_wr_o;
  logic [15:0] buf_rdata_i, buf_wdata_o;

  always #2.5 clk_i = ~clk_i;

  ata_pio_sector_seq #(.WORDS(WORDS), .SEL_WAIT(SEL_WAIT), .TIMEOUT(TIMEOUT)) dut (.*);

  function automatic logic [15:0] wpat(int i); return 16'(i * 257) ^ 16'h5a3c; endfunction
  function automatic logic [15:0] rpat(int i); return 16'(i * 3 + 16'h1234); endfunction
  assign buf_rdata_i = wpat(int'(buf_idx_o));

  int errors = 0, checks = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive and arbiter model configuration
  int cfg_bsy = 2, cfg_bsy2 = 2, gnt_delay = 2;
  bit cfg_err_cmd = 0, cfg_err_drq = 0, cfg_err_final = 0, cfg_no_irq = 0, cfg_early = 0, cfg_stale = 0;
  // model state
  int ph = 0, bsy_left = 0, bsy2_left = 0, wcount = 0, rcount = 0, irq_cnt = -1, irq_hold = 0;
  bit is_wr = 0, first_sel = 0;
  int gcnt = 0, cyc = 0, alt_reads = 0, status_reads = 0, sel_cycle = 0, ctrl_cycle = 0;
  bit saw_done = 0, saw_err = 0;
  logic [19:0] expw[$];
  logic [15:0] rbuf [WORDS];

  always @(negedge clk_i) begin
    logic [15:0] r;
    cyc++;
    r = tf_rdata_i;
    if (rst_ni) begin
      if (tf_wr_o || tf_rd_o)
        chk(lock_gnt_i && lock_req_o, "R10", "access without lock", lock_gnt_i, 1);
      if (done_o) saw_done = 1;
      if (err_o) saw_err = 1;
      if (done_o || err_o) chk(!lock_req_o, "R9", "lock held at end", lock_req_o, 0);
      if (tf_wr_o) begin
        if (expw.size() == 0) chk(0, "R2", "unexpected write", {tf_reg_o, tf_wdata_o}, 0);
        else begin
          logic [19:0] e;
          e = expw.pop_front();
          chk({tf_reg_o, tf_wdata_o} == e, (tf_reg_o == 4'd0) ? "R5" : "R2", "write",
              {tf_reg_o, tf_wdata_o}, e);
        end
        if (tf_reg_o == 4'd6 && first_sel) begin
          first_sel = 0; sel_cycle = cyc;
          if (cfg_stale) irq_cnt = 2;
        end
        if (tf_reg_o == 4'd8) ctrl_cycle = cyc;
        if (tf_reg_o == 4'd7) begin
          ph = 1; bsy_left = cfg_bsy; wcount = 0; rcount = 0; status_reads = 0;
          is_wr = (tf_wdata_o[7:0] == 8'h30);
          if (cfg_early) irq_cnt = 1;
        end
        if (tf_reg_o == 4'd0) begin
          wcount++;
          if (wcount == WORDS) begin ph = 3; bsy2_left = cfg_bsy2; end
        end
      end
      if (tf_rd_o) begin
        case (tf_reg_o)
          4'd8: begin alt_reads++; r = 16'h0050; end
          4'd0: begin r = rpat(rcount); rcount++; if (rcount == WORDS) ph = 7; end
          default: begin
            status_reads++;
            case (ph)
              1: if (bsy_left > 0) begin bsy_left--; r = 16'h0080; end
                 else if (cfg_err_cmd) begin r = 16'h0041; ph = 9; end
                 else begin
                   r = 16'h0050;
                   if (is_wr) ph = 2;
                   else begin ph = cfg_early ? 6 : 4; if (!cfg_early && !cfg_no_irq) irq_cnt = 3; end
                 end
              2: r = 16'h0058 | 16'(cfg_err_drq);
              3: if (bsy2_left > 0) begin bsy2_left--; r = 16'h0080; end
                 else begin r = 16'h0050; ph = 5; if (!cfg_early && !cfg_no_irq) irq_cnt = 3; end
              4: r = 16'h0080;
              5, 7: r = 16'h0050 | 16'(cfg_err_final);
              6: r = 16'h0058;
              9: r = 16'h0041;
              default: r = 16'h0050;
            endcase
          end
        endcase
      end
      // interrupt pulse generation
      if (irq_hold > 0) begin irq_hold--; if (irq_hold == 0) irq_i = 0; end
      if (irq_cnt > 0) irq_cnt--;
      else if (irq_cnt == 0) begin
        irq_cnt = -1; irq_i = 1; irq_hold = 2;
        if (ph == 4) ph = 6;
      end
      // lock arbiter
      if (lock_req_o) gcnt++; else gcnt = 0;
      lock_gnt_i = lock_req_o && (gcnt > gnt_delay);
    end
    tf_rdata_i = r;
    #1;
    if (rst_ni && buf_wr_o) rbuf[buf_idx_o] = buf_wdata_o;
  end

  task automatic run(bit wr, bit sl, logic [7:0] s, logic [7:0] cl, logic [7:0] ch, logic [3:0] hd);
    logic [7:0] sel;
    int wd;
    sel = 8'hA0 | {3'b0, sl, 4'b0};
    expw.delete();
    expw.push_back({4'd6, 8'h00, sel});
    expw.push_back({4'd8, 16'h0008});
    expw.push_back({4'd1, 16'h0001});
    expw.push_back({4'd1, 16'h0000});
    expw.push_back({4'd2, 16'h0001});
    expw.push_back({4'd3, 8'h00, s});
    expw.push_back({4'd4, 8'h00, cl});
    expw.push_back({4'd5, 8'h00, ch});
    expw.push_back({4'd6, 8'h00, sel | {4'h0, hd}});
    expw.push_back({4'd7, 8'h00, wr ? 8'h30 : 8'h20});
    if (wr) for (int i = 0; i < WORDS; i++) expw.push_back({4'd0, wpat(i)});
    for (int i = 0; i < WORDS; i++) rbuf[i] = 16'hdead;
    saw_done = 0; saw_err = 0; alt_reads = 0; first_sel = 1; ph = 0; wcount = 0; rcount = 0;
    @(negedge clk_i);
    chk(!busy_o, "R12", "busy before request", busy_o, 0);
    req_valid_i = 1; req_write_i = wr; req_slave_i = sl;
    req_sect_i = s; req_cyl_lo_i = cl; req_cyl_hi_i = ch; req_head_i = hd;
    @(negedge clk_i);
    req_valid_i = 0;
    chk(lock_req_o, "R10", "lock request after accept", lock_req_o, 1);
    wd = 0;
    while (!saw_done && !saw_err && wd < 20000) begin @(negedge clk_i); wd++; end
    if (wd >= 20000) chk(0, "WD", "watchdog", wd, 0);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !lock_req_o && !done_o && !err_o && !tf_wr_o && !tf_rd_o, "R12", "reset state",
        {busy_o, lock_req_o, done_o, err_o, tf_wr_o, tf_rd_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // normal write, master
    gnt_delay = 3;
    run(1, 0, 8'h05, 8'h12, 8'h34, 4'h3);
    chk(saw_done && !saw_err, "R9", "write outcome", {saw_done, saw_err}, 2);
    chk(expw.size() == 0, "R5", "write words remaining", expw.size(), 0);
    chk(alt_reads == 1, "R6", "write alt reads", alt_reads, 1);
    chk(ctrl_cycle - sel_cycle == SEL_WAIT + 1, "R1", "settle gap", ctrl_cycle - sel_cycle, SEL_WAIT + 1);

    // normal read, slave; also a request offered while busy
    gnt_delay = 10;
    fork
      run(0, 1, 8'h3f, 8'hab, 8'h01, 4'ha);
      begin
        repeat (40) @(negedge clk_i);
        req_valid_i = 1; req_write_i = 1;
        @(negedge clk_i);
        req_valid_i = 0; req_write_i = 0;
      end
    join
    chk(saw_done && !saw_err, "R9", "read outcome", {saw_done, saw_err}, 2);
    chk(expw.size() == 0, "R2", "read setup remaining", expw.size(), 0);
    chk(alt_reads == 2, "R6", "read alt reads", alt_reads, 2);
    begin
      int bad = 0;
      for (int i = 0; i < WORDS; i++) if (rbuf[i] != rpat(i)) bad++;
      chk(bad == 0, "R7", "read buffer mismatches", bad, 0);
    end
    repeat (6) @(negedge clk_i);
    chk(!busy_o && !lock_req_o, "R12", "request while busy ignored", {busy_o, lock_req_o}, 0);

    // error at command completion
    gnt_delay = 1; cfg_err_cmd = 1;
    run(0, 0, 8'h01, 8'h00, 8'h00, 4'h0);
    chk(saw_err && !saw_done, "R4", "cmd error outcome", {saw_done, saw_err}, 1);
    chk(rcount == 0 && alt_reads == 0, "R4", "no data after cmd error", rcount + alt_reads, 0);
    cfg_err_cmd = 0;

    // error during write DRQ poll
    cfg_err_drq = 1;
    run(1, 1, 8'h02, 8'h00, 8'h00, 4'h1);
    chk(saw_err && !saw_done, "R5", "drq error outcome", {saw_done, saw_err}, 1);
    chk(wcount == 0, "R5", "words before drq error", wcount, 0);
    cfg_err_drq = 0;

    // error on the final status check
    cfg_err_final = 1;
    run(0, 0, 8'h07, 8'h10, 8'h20, 4'h2);
    chk(saw_err && !saw_done, "R9", "final error outcome", {saw_done, saw_err}, 1);
    chk(rcount == WORDS && alt_reads == 2, "R9", "final error after full data", rcount, WORDS);
    cfg_err_final = 0;

    // drive stuck busy
    cfg_bsy = 1000;
    run(1, 0, 8'h09, 8'h00, 8'h00, 4'h0);
    chk(saw_err && !saw_done, "R11", "timeout outcome", {saw_done, saw_err}, 1);
    chk(status_reads == TIMEOUT, "R11", "polls before timeout", status_reads, TIMEOUT);
    cfg_bsy = 5;

    // interrupt arrives while still polling busy (read)
    cfg_early = 1;
    run(0, 1, 8'h11, 8'h22, 8'h33, 4'h4);
    chk(saw_done && !saw_err, "R8", "early interrupt kept", {saw_done, saw_err}, 2);
    chk(alt_reads == 2 && rcount == WORDS, "R8", "early interrupt data", rcount, WORDS);
    cfg_early = 0;

    // interrupt only before the command: must be ignored
    cfg_stale = 1; cfg_no_irq = 1;
    run(1, 0, 8'h44, 8'h55, 8'h66, 4'h5);
    chk(saw_err && !saw_done, "R8", "stale interrupt ignored", {saw_done, saw_err}, 1);
    chk(alt_reads == 0 && wcount == WORDS, "R11", "interrupt wait timed out", alt_reads, 0);
    cfg_stale = 0; cfg_no_irq = 0;

    // back-to-back normal write after errors
    cfg_bsy = 2;
    run(1, 1, 8'hfe, 8'hff, 8'hff, 4'hf);
    chk(saw_done && !saw_err, "R3", "recovery write outcome", {saw_done, saw_err}, 2);
    chk(expw.size() == 0, "R5", "recovery words remaining", expw.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    errors++; checks++;
    $display("FAIL WD global watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule